// File: doc/BRIEF.md
# Vector Compare to Predicate Mask

This block turns one compare into a loop over a short vector. It compares up to VL pairs of elements and sets one predicate bit for each element index where the compare is true. Each of the two sources is either a vector or a scalar. A vector source walks through consecutive registers starting at its base register. A scalar source gives its base register to every element.

The block takes one element per cycle. It drives two register-file read addresses and receives the two operand values back in the same cycle. Result bits are ORed into a copy of the target predicate register, which is supplied at start. The merged mask goes out on a single write port when the loop ends. If neither source is a vector, the block builds no mask and flags the operation as an ordinary scalar branch.

Top module: `vcmp_mask`

## Requirements
- R1: After reset, busy_o, rd_en_o, done_o, scalar_o and wr_en_o are all low.
- R2: op_i selects the compare on operands a and b: 2'b00 a==b, 2'b01 a!=b, 2'b10 signed a<b, 2'b11 unsigned a<b. Bit i of the result is set when the compare on element i is true.
- R3: In element cycle i, a vector source is read at its base plus i (modulo the register count). A scalar source is read at its base in every element cycle.
- R4: Result bits are ORed into pred_old_i, so a bit that was already set stays set.
- R5: Bits of the written mask at index VL and above equal the same bits of pred_old_i.
- R6: With VL>0 and at least one vector source, rd_en_o is high for VL cycles, one element each. In the next cycle done_o and wr_en_o pulse for one cycle, with wr_addr_o equal to the target and wr_data_o equal to the mask.
- R7: With VL=0 and at least one vector source, done_o and wr_en_o pulse in the first cycle after start, and the written value is pred_old_i unchanged.
- R8: With neither source a vector, done_o and scalar_o pulse in the first cycle after start, and wr_en_o stays low.
- R9: A start_i pulse while busy_o is high has no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation, accepted while idle |
| op_i | input | 2 | Compare select |
| vl_i | input | $clog2(XLEN+1) | Element count, 0 to XLEN |
| src_base_a_i | input | $clog2(NREG) | Base register of operand a |
| src_vec_a_i | input | 1 | Operand a is a vector |
| src_base_b_i | input | $clog2(NREG) | Base register of operand b |
| src_vec_b_i | input | 1 | Operand b is a vector |
| tgt_i | input | $clog2(NREG) | Target predicate register |
| pred_old_i | input | XLEN | Current value of the target predicate register |
| rd_en_o | output | 1 | Element read cycle |
| rd_addr_a_o | output | $clog2(NREG) | Read address for operand a |
| rd_addr_b_o | output | $clog2(NREG) | Read address for operand b |
| rd_data_a_i | input | XLEN | Operand a value, same cycle |
| rd_data_b_i | input | XLEN | Operand b value, same cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished, one-cycle pulse |
| scalar_o | output | 1 | All-scalar operation, no mask built |
| wr_en_o | output | 1 | Write the predicate register |
| wr_addr_o | output | $clog2(NREG) | Predicate register written |
| wr_data_o | output | XLEN | Merged mask |

## Verification
The hardest case to reach is a second start pulse that arrives in the middle of a loop. If it were wrongly accepted, it would reload the target, the base registers and the accumulator without any visible sign until the write-back. The stimulus raises start_i with a different target and compare code two cycles into a multi-element loop. The bench then checks that the loop length, the write address and the mask all belong to the first operation. Signed and unsigned less-than are told apart by register contents whose top bit varies from register to register, so the two codes produce different masks on the same sources.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef enum logic [1:0] {
    CMP_EQ  = 2'b00,
    CMP_NE  = 2'b01,
    CMP_SLT = 2'b10,
    CMP_ULT = 2'b11
  } cmp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_SCL  = 2'd3
  } vcmp_state_e;
endpackage

// File: rtl/vcmp_cmp.sv
module vcmp_cmp
  import vcmp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  cmp_op_e      op_i,
  output logic         hit_o
);
  always_comb begin
    unique case (op_i)
      CMP_EQ:  hit_o = (a_i == b_i);
      CMP_NE:  hit_o = (a_i != b_i);
      CMP_SLT: hit_o = ($signed(a_i) < $signed(b_i));
      default: hit_o = (a_i < b_i);
    endcase
  end
endmodule

// File: rtl/vcmp_src_addr.sv
module vcmp_src_addr #(
  parameter int unsigned RIDW = 5,
  parameter int unsigned VLW  = 6
) (
  input  logic [RIDW-1:0] base_i,
  input  logic            vec_i,
  input  logic [VLW-1:0]  idx_i,
  output logic [RIDW-1:0] addr_o
);
  logic [RIDW-1:0] step;

  // register index wraps modulo the register count
  assign step   = RIDW'(idx_i);
  assign addr_o = vec_i ? base_i + step : base_i;
endmodule

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl
  import vcmp_pkg::*;
#(
  parameter int unsigned VLW = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [VLW-1:0] vl_i,
  input  logic           any_vec_i,
  output vcmp_state_e    state_o,
  output logic [VLW-1:0] idx_o,
  output logic           accept_o
);
  vcmp_state_e    state_q;
  logic [VLW-1:0] idx_q;
  logic [VLW-1:0] vl_q;
  logic           last;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign last     = (idx_q == vl_q - VLW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      vl_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            idx_q <= '0;
            vl_q  <= vl_i;
            if (!any_vec_i)       state_q <= ST_SCL;
            else if (vl_i == '0)  state_q <= ST_FIN;
            else                  state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          idx_q <= idx_q + VLW'(1);
          if (last) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/vcmp_mask.sv
module vcmp_mask
  import vcmp_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned VLW  = $clog2(XLEN + 1),
  localparam int unsigned RIDW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic [RIDW-1:0] src_base_a_i,
  input  logic            src_vec_a_i,
  input  logic [RIDW-1:0] src_base_b_i,
  input  logic            src_vec_b_i,
  input  logic [RIDW-1:0] tgt_i,
  input  logic [XLEN-1:0] pred_old_i,
  output logic            rd_en_o,
  output logic [RIDW-1:0] rd_addr_a_o,
  output logic [RIDW-1:0] rd_addr_b_o,
  input  logic [XLEN-1:0] rd_data_a_i,
  input  logic [XLEN-1:0] rd_data_b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            scalar_o,
  output logic            wr_en_o,
  output logic [RIDW-1:0] wr_addr_o,
  output logic [XLEN-1:0] wr_data_o
);
  localparam int unsigned NSRC = 2;

  vcmp_state_e     state;
  logic [VLW-1:0]  idx;
  logic            accept;
  logic            hit;
  cmp_op_e         op_q;
  logic [RIDW-1:0] tgt_q;
  logic [XLEN-1:0] acc_q;
  logic [RIDW-1:0] base_in [NSRC];
  logic            vec_in  [NSRC];
  logic [RIDW-1:0] base_q  [NSRC];
  logic            vec_q   [NSRC];
  logic [RIDW-1:0] addr    [NSRC];
  logic [XLEN-1:0] hit_vec;

  assign base_in[0] = src_base_a_i;
  assign base_in[1] = src_base_b_i;
  assign vec_in[0]  = src_vec_a_i;
  assign vec_in[1]  = src_vec_b_i;

  vcmp_ctrl #(.VLW(VLW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .vl_i      (vl_i),
    .any_vec_i (src_vec_a_i | src_vec_b_i),
    .state_o   (state),
    .idx_o     (idx),
    .accept_o  (accept)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g] <= '0;
        vec_q[g]  <= 1'b0;
      end else if (accept) begin
        base_q[g] <= base_in[g];
        vec_q[g]  <= vec_in[g];
      end
    end

    vcmp_src_addr #(.RIDW(RIDW), .VLW(VLW)) u_addr (
      .base_i (base_q[g]),
      .vec_i  (vec_q[g]),
      .idx_i  (idx),
      .addr_o (addr[g])
    );
  end

  vcmp_cmp #(.W(XLEN)) u_cmp (
    .a_i   (rd_data_a_i),
    .b_i   (rd_data_b_i),
    .op_i  (op_q),
    .hit_o (hit)
  );

  assign hit_vec = {{(XLEN-1){1'b0}}, hit} << idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= CMP_EQ;
      tgt_q <= '0;
      acc_q <= '0;
    end else if (accept) begin
      op_q  <= cmp_op_e'(op_i);
      tgt_q <= tgt_i;
      acc_q <= pred_old_i;
    end else if (state == ST_RUN) begin
      acc_q <= acc_q | hit_vec;
    end
  end

  assign rd_en_o     = (state == ST_RUN);
  assign rd_addr_a_o = addr[0];
  assign rd_addr_b_o = addr[1];
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_FIN) || (state == ST_SCL);
  assign scalar_o    = (state == ST_SCL);
  assign wr_en_o     = (state == ST_FIN);
  assign wr_addr_o   = tgt_q;
  assign wr_data_o   = acc_q;
endmodule

// File: rtl/vcmp_mask_chk.sv
module vcmp_mask_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned VLW  = $clog2(XLEN + 1),
  localparam int unsigned RIDW = $clog2(NREG)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [VLW-1:0]  vl_i,
  input logic [RIDW-1:0] src_base_a_i,
  input logic            src_vec_a_i,
  input logic [XLEN-1:0] pred_old_i,
  input logic            rd_en_o,
  input logic [RIDW-1:0] rd_addr_a_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            scalar_o,
  input logic            wr_en_o,
  input logic [XLEN-1:0] wr_data_o
);
  logic [XLEN-1:0] old_q;
  logic [VLW-1:0]  vl_q;
  logic [RIDW-1:0] ba_q;
  logic            va_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      old_q <= '0;
      vl_q  <= '0;
      ba_q  <= '0;
      va_q  <= 1'b0;
    end else if (start_i && !busy_o) begin
      old_q <= pred_old_i;
      vl_q  <= vl_i;
      ba_q  <= src_base_a_i;
      va_q  <= src_vec_a_i;
    end
  end

  function automatic logic [XLEN-1:0] upper_bits(input logic [VLW-1:0] n);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = (i >= int'(n));
    return m;
  endfunction

  p_wr_needs_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> done_o);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_scalar_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scalar_o |-> (done_o && !wr_en_o && !rd_en_o));

  p_keep_set_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ((wr_data_o & old_q) == old_q));

  p_upper_untouched_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (((wr_data_o ^ old_q) & upper_bits(vl_q)) == '0));

  p_scalar_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && !va_q) |-> (rd_addr_a_o == ba_q));

  p_vector_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && va_q && $past(rd_en_o)) |-> (rd_addr_a_o == RIDW'($past(rd_addr_a_o) + 1'b1)));

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && start_i) |=> busy_o);
endmodule

bind vcmp_mask vcmp_mask_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .vl_i         (vl_i),
  .src_base_a_i (src_base_a_i),
  .src_vec_a_i  (src_vec_a_i),
  .pred_old_i   (pred_old_i),
  .rd_en_o      (rd_en_o),
  .rd_addr_a_o  (rd_addr_a_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .scalar_o     (scalar_o),
  .wr_en_o      (wr_en_o),
  .wr_data_o    (wr_data_o)
);

// File: tb/sim_vcmp_mask.sv
module sim_vcmp_mask;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int VLW  = $clog2(XLEN + 1);
  localparam int RIDW = $clog2(NREG);

  typedef struct packed {
    logic [1:0]      op;
    logic [VLW-1:0]  vl;
    logic [RIDW-1:0] ba;
    logic            va;
    logic [RIDW-1:0] bb;
    logic            vb;
    logic [RIDW-1:0] tgt;
    logic [XLEN-1:0] old;
  } vec_t;

  localparam int NVEC = 10;
  // op, vl, base a, vec a, base b, vec b, target, old predicate
  localparam vec_t TBL [NVEC] = '{
    '{2'b00, 6'd8,  5'd4,  1'b1, 5'd20, 1'b1, 5'd1,  32'h0000_0000},
    '{2'b01, 6'd8,  5'd4,  1'b1, 5'd20, 1'b1, 5'd2,  32'hF000_0000},
    '{2'b10, 6'd6,  5'd1,  1'b1, 5'd3,  1'b0, 5'd3,  32'h0000_0000},
    '{2'b11, 6'd6,  5'd1,  1'b1, 5'd3,  1'b0, 5'd4,  32'h0000_0000},
    '{2'b10, 6'd5,  5'd7,  1'b0, 5'd9,  1'b1, 5'd5,  32'h0000_0005},
    '{2'b11, 6'd32, 5'd0,  1'b1, 5'd0,  1'b0, 5'd6,  32'h0000_0000},
    '{2'b00, 6'd3,  5'd4,  1'b1, 5'd20, 1'b1, 5'd7,  32'hFFFF_FF00},
    '{2'b01, 6'd0,  5'd4,  1'b1, 5'd20, 1'b1, 5'd8,  32'h0000_1234},
    '{2'b00, 6'd4,  5'd4,  1'b0, 5'd20, 1'b0, 5'd9,  32'h0000_00FF},
    '{2'b10, 6'd12, 5'd26, 1'b1, 5'd12, 1'b1, 5'd10, 32'h00A0_0000}
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [1:0]      op_i = '0;
  logic [VLW-1:0]  vl_i = '0;
  logic [RIDW-1:0] src_base_a_i = '0;
  logic            src_vec_a_i = 1'b0;
  logic [RIDW-1:0] src_base_b_i = '0;
  logic            src_vec_b_i = 1'b0;
  logic [RIDW-1:0] tgt_i = '0;
  logic [XLEN-1:0] pred_old_i = '0;
  logic            rd_en_o;
  logic [RIDW-1:0] rd_addr_a_o, rd_addr_b_o;
  logic [XLEN-1:0] rd_data_a_i, rd_data_b_i;
  logic            busy_o, done_o, scalar_o, wr_en_o;
  logic [RIDW-1:0] wr_addr_o;
  logic [XLEN-1:0] wr_data_o;

  logic [XLEN-1:0] rf [NREG];
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  assign rd_data_a_i = rf[rd_addr_a_i_idx()];
  assign rd_data_b_i = rf[rd_addr_b_o];

  function automatic logic [RIDW-1:0] rd_addr_a_i_idx();
    return rd_addr_a_o;
  endfunction

  vcmp_mask #(.XLEN(XLEN), .NREG(NREG)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] model(input vec_t v);
    logic [XLEN-1:0] m = v.old;
    for (int i = 0; i < int'(v.vl); i++) begin
      logic [XLEN-1:0] a = rf[v.va ? RIDW'(v.ba + i) : v.ba];
      logic [XLEN-1:0] b = rf[v.vb ? RIDW'(v.bb + i) : v.bb];
      bit t;
      case (v.op)
        2'b00:   t = (a == b);
        2'b01:   t = (a != b);
        2'b10:   t = ($signed(a) < $signed(b));
        default: t = (a < b);
      endcase
      if (t) m[i] = 1'b1;
    end
    return m;
  endfunction

  task automatic run_op(input vec_t v, input bit poke);
    int k = 0;
    bit scl = !(v.va || v.vb);
    int exp_k = (scl || v.vl == 0) ? 1 : int'(v.vl) + 1;
    @(negedge clk_i);
    op_i = v.op; vl_i = v.vl; src_base_a_i = v.ba; src_vec_a_i = v.va;
    src_base_b_i = v.bb; src_vec_b_i = v.vb; tgt_i = v.tgt; pred_old_i = v.old;
    start_i = 1'b1;
    while (1) begin
      @(negedge clk_i);
      start_i = 1'b0;
      k++;
      if (rd_en_o) begin
        // R3 per element read address
        chk(rd_addr_a_o == (v.va ? RIDW'(v.ba + k - 1) : v.ba), "R3 addr a",
            XLEN'(rd_addr_a_o), XLEN'(v.va ? RIDW'(v.ba + k - 1) : v.ba));
        chk(rd_addr_b_o == (v.vb ? RIDW'(v.bb + k - 1) : v.bb), "R3 addr b",
            XLEN'(rd_addr_b_o), XLEN'(v.vb ? RIDW'(v.bb + k - 1) : v.bb));
      end
      if (done_o || k > 80) break;
      if (poke && k == 2) begin
        // R9 second start mid-loop with other target and compare
        start_i = 1'b1; tgt_i = ~v.tgt; op_i = ~v.op; pred_old_i = '1;
      end
    end
    chk(k == exp_k, scl ? "R8 latency" : (v.vl == 0 ? "R7 latency" : "R6 latency"),
        XLEN'(k), XLEN'(exp_k));
    chk(scalar_o == scl, "R8 scalar flag", XLEN'(scalar_o), XLEN'(scl));
    chk(wr_en_o == !scl, "R6 write enable", XLEN'(wr_en_o), XLEN'(!scl));
    if (!scl) begin
      chk(wr_addr_o == v.tgt, "R6 write address", XLEN'(wr_addr_o), XLEN'(v.tgt));
      chk(wr_data_o == model(v), "R2 R4 R5 mask", wr_data_o, model(v));
    end
    @(negedge clk_i);
    chk(!done_o && !wr_en_o, "R6 single pulse", XLEN'({done_o, wr_en_o}), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NREG; k++)
      rf[k] = XLEN'(k * 32'h1357_9BDF) ^ ((k % 3 == 0) ? 32'h8000_0000 : 32'h0);
    for (int k = 20; k < 28; k++)
      rf[k] = (k == 22 || k == 25) ? rf[k-16] + 32'd1 : rf[k-16];

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!busy_o && !rd_en_o && !done_o && !scalar_o && !wr_en_o, "R1 reset outputs",
        XLEN'({busy_o, rd_en_o, done_o, scalar_o, wr_en_o}), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !wr_en_o, "R1 idle after reset",
        XLEN'({busy_o, done_o, wr_en_o}), '0);

    for (int n = 0; n < NVEC; n++) run_op(TBL[n], 1'b0);

    // R9 start ignored while busy
    run_op(TBL[0], 1'b1);
    run_op(TBL[9], 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule